// File: doc/BRIEF.md
# Single-Cycle 8-bit Processor Core

This block is a small processor. It uses 16-bit instruction words and 8-bit data, and each instruction completes in one clock cycle. The core holds four pieces of state: a 16-word by 8-bit data memory, a 16-entry by 8-bit register file, a program counter, and a read-only instruction store. The instruction store is filled from a parameter vector at elaboration. The core supports four operations: an immediate or register store into data memory, a load from data memory into a register, an unsigned wrapping add, and a compare-and-branch relative to the program counter.

Work is driven one instruction at a time. On a cycle where `exec_i` is high, the core executes one word and commits its result at that clock edge. `src_ext_i` selects where that word comes from: the instruction store at the program counter, or the word on `ext_instr_i`. A word from the store advances the program counter. A word from the external port never moves it.

The word at the program counter is presented continuously on `next_instr_o`, so it can drive indicator lights. Any data memory word can be read combinationally through the debug address port.

Top module: `sc8_core`

## Requirements
- R1: While reset is asserted, `pc_o` is 0, and every data memory word and every register reads 0.
- R2: On a cycle with `exec_i` low, no state changes: the program counter, the data memory and the registers hold their values.
- R3: Opcode bits [15:13] = 000 with bit 12 = 1 writes the immediate in bits [7:0] to the data memory word addressed by bits [11:8].
- R4: Opcode 000 with bit 12 = 0 writes register rf[[3:0]] to the data memory word addressed by bits [11:8].
- R5: Opcode 001 copies the data memory word addressed by bits [3:0] into register rf[[7:4]]. Bits [11:8] are ignored.
- R6: Opcode 010 writes rf[[7:4]] + rf[[3:0]] to rf[[11:8]], modulo 256. Bit 12 is ignored.
- R7: Opcode 101 executed from the store compares rf[[11:8]] with rf[[7:4]]. If they are equal, the PC becomes PC+1 plus bits [3:0] read as a signed two's complement offset. If they differ, the PC becomes PC+1.
- R8: Any other instruction executed from the store advances the PC by one, wrapping from the last entry to 0.
- R9: An instruction taken from `ext_instr_i` (`src_ext_i` = 1) updates registers and data memory as its opcode says and leaves the PC unchanged, even for opcode 101.
- R10: Opcodes 011, 100, 110 and 111 change no register and no data memory word.
- R11: `next_instr_o` always equals the instruction store entry at the current PC.
- R12: `dbg_data_o` shows the data memory word at `dbg_addr_i` in the same cycle. A write becomes visible there right after the clock edge that commits it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| exec_i | input | 1 | Execute one instruction this cycle |
| src_ext_i | input | 1 | 1: execute `ext_instr_i`; 0: execute the store word at the PC |
| ext_instr_i | input | 16 | Externally supplied instruction word |
| dbg_addr_i | input | 4 | Data memory debug read address |
| dbg_data_o | output | 8 | Data memory word at `dbg_addr_i` |
| next_instr_o | output | 16 | Instruction store entry at the PC |
| pc_o | output | PC_W (4) | Program counter |

## Verification
Every result is due at the clock edge that samples `exec_i` high. After that edge, the written register or memory word, `pc_o` and `next_instr_o` are all settled. The debug read is combinational, so a memory word can be read in any cycle with no added latency. Registers are seen only through a later register store into memory.

The bench drives each instruction on a falling edge and holds it across exactly one rising edge. It then drops `exec_i` on the next falling edge, and only after that compares the PC, the next-instruction word and a sweep of all memory words against its own model. Reset release passes through a two-stage synchronizer, so the bench waits three cycles after deasserting `rst_n` before the first execute.

// File: rtl/sc8_pkg.sv
package sc8_pkg;
  localparam int INSTR_W = 16;
  localparam int DATA_W  = 8;
  localparam int FIELD_W = 4;
  localparam int BANK_DEPTH = 1 << FIELD_W;

  typedef enum logic [2:0] {
    OP_STORE = 3'b000,
    OP_LOAD  = 3'b001,
    OP_ADD   = 3'b010,
    OP_RSV3  = 3'b011,
    OP_RSV4  = 3'b100,
    OP_BEQ   = 3'b101,
    OP_RSV6  = 3'b110,
    OP_RSV7  = 3'b111
  } opcode_e;

  typedef struct packed {
    logic rf_we;
    logic rf_load;
    logic dm_we;
    logic dm_imm;
    logic is_beq;
  } ctrl_t;
endpackage

// File: rtl/sc8_rst_sync.sv
module sc8_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/sc8_decode.sv
module sc8_decode
  import sc8_pkg::*;
(
  input  logic [3:0] head_i,
  output ctrl_t      ctrl_o
);
  opcode_e op;
  assign op = opcode_e'(head_i[3:1]);

  always_comb begin
    ctrl_o = '0;
    unique case (op)
      OP_STORE: begin
        ctrl_o.dm_we  = 1'b1;
        ctrl_o.dm_imm = head_i[0];
      end
      OP_LOAD: begin
        ctrl_o.rf_we   = 1'b1;
        ctrl_o.rf_load = 1'b1;
      end
      OP_ADD:  ctrl_o.rf_we  = 1'b1;
      OP_BEQ:  ctrl_o.is_beq = 1'b1;
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/sc8_bank.sv
module sc8_bank #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [NRD*AW-1:0] raddr_i,
  output logic [NRD*W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];
  logic [W-1:0] mem_d [DEPTH];

  always_comb begin
    mem_d = mem_q;
    if (we_i) mem_d[waddr_i] = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '{default: '0};
    else        mem_q <= mem_d;
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rdata_o[k*W +: W] = mem_q[raddr_i[k*AW +: AW]];
  end
endmodule

// File: rtl/sc8_pc.sv
module sc8_pc #(
  parameter int PC_W = 4,
  parameter int OFF_W = 4,
  localparam int SUM_W = (PC_W > OFF_W) ? PC_W : OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             take_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PC_W-1:0]  pc_o
);
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [SUM_W-1:0] off_ext;

  assign off_ext = SUM_W'(signed'(off_i));

  always_comb begin
    pc_d = pc_q;
    if (step_i)
      pc_d = PC_W'(SUM_W'(pc_q) + SUM_W'(1) + (take_i ? off_ext : '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/sc8_core.sv
module sc8_core
  import sc8_pkg::*;
#(
  parameter int IMEM_DEPTH = 16,
  parameter logic [IMEM_DEPTH*INSTR_W-1:0] ROM_IMAGE = {
    16'h0000, 16'h0000, 16'h0000, 16'h0000,
    16'h0000, 16'h0000, 16'h0000, 16'h0000,
    16'h0000, 16'h0000, 16'h0000, 16'h0203,
    16'h4312, 16'h2021, 16'h2010, 16'h1005},
  localparam int PC_W = $clog2(IMEM_DEPTH),
  localparam int FW   = FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_i,
  input  logic               src_ext_i,
  input  logic [INSTR_W-1:0] ext_instr_i,
  input  logic [FW-1:0]      dbg_addr_i,
  output logic [DATA_W-1:0]  dbg_data_o,
  output logic [INSTR_W-1:0] next_instr_o,
  output logic [PC_W-1:0]    pc_o
);
  logic               rst_sync_n;
  logic [INSTR_W-1:0] rom_w [IMEM_DEPTH];
  logic [INSTR_W-1:0] cur_instr;
  logic [FW-1:0]      f_hi, f_mid, f_lo;
  ctrl_t              ctrl;
  logic [DATA_W-1:0]  rf_a, rf_b, rf_c, dm_ld;
  logic               rf_we, dm_we, step, take;
  logic [FW-1:0]      rf_waddr;
  logic [DATA_W-1:0]  rf_wdata, dm_wdata;

  sc8_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  for (genvar g = 0; g < IMEM_DEPTH; g++) begin : g_rom
    assign rom_w[g] = ROM_IMAGE[g*INSTR_W +: INSTR_W];
  end

  assign next_instr_o = rom_w[pc_o];
  assign cur_instr    = src_ext_i ? ext_instr_i : next_instr_o;
  assign f_hi  = cur_instr[11:8];
  assign f_mid = cur_instr[7:4];
  assign f_lo  = cur_instr[3:0];

  sc8_decode u_dec (.head_i(cur_instr[15:12]), .ctrl_o(ctrl));

  assign rf_we    = exec_i & ctrl.rf_we;
  assign rf_waddr = ctrl.rf_load ? f_mid : f_hi;
  assign rf_wdata = ctrl.rf_load ? dm_ld : DATA_W'(rf_b + rf_c);

  sc8_bank #(.W(DATA_W), .DEPTH(BANK_DEPTH), .NRD(3)) u_rf (
    .clk(clk), .rst_n(rst_sync_n),
    .we_i(rf_we), .waddr_i(rf_waddr), .wdata_i(rf_wdata),
    .raddr_i({f_lo, f_mid, f_hi}),
    .rdata_o({rf_c, rf_b, rf_a})
  );

  assign dm_we    = exec_i & ctrl.dm_we;
  assign dm_wdata = ctrl.dm_imm ? cur_instr[7:0] : rf_c;

  sc8_bank #(.W(DATA_W), .DEPTH(BANK_DEPTH), .NRD(2)) u_dm (
    .clk(clk), .rst_n(rst_sync_n),
    .we_i(dm_we), .waddr_i(f_hi), .wdata_i(dm_wdata),
    .raddr_i({dbg_addr_i, f_lo}),
    .rdata_o({dbg_data_o, dm_ld})
  );

  assign step = exec_i & ~src_ext_i;
  assign take = ctrl.is_beq & (rf_a == rf_b);

  sc8_pc #(.PC_W(PC_W), .OFF_W(FW)) u_pc (
    .clk(clk), .rst_n(rst_sync_n),
    .step_i(step), .take_i(take), .off_i(f_lo), .pc_o(pc_o)
  );
endmodule

// File: rtl/sc8_core_chk.sv
module sc8_core_chk #(
  parameter int PC_W = 4
) (
  input logic            clk,
  input logic            rst_ok,
  input logic            exec_i,
  input logic            src_ext_i,
  input logic [15:0]     cur_instr,
  input logic [PC_W-1:0] pc_o,
  input logic [3:0]      dbg_addr_i,
  input logic [7:0]      dbg_data_o
);
  AST_RESET_PC_ZERO: assert property (@(posedge clk) !rst_ok |-> pc_o == '0); // R1

  AST_IDLE_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !exec_i |=> $stable(pc_o)); // R2

  AST_IDLE_DMEM_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !exec_i |=> (dbg_addr_i != $past(dbg_addr_i)) || $stable(dbg_data_o)); // R2

  AST_IMM_STORE_LANDS: assert property (@(posedge clk) disable iff (!rst_ok)
    (exec_i && cur_instr[15:12] == 4'b0001 && dbg_addr_i == cur_instr[11:8])
    |=> (dbg_addr_i != $past(dbg_addr_i)) || dbg_data_o == $past(cur_instr[7:0])); // R3

  AST_ROM_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_ok)
    (exec_i && !src_ext_i && cur_instr[15:13] != 3'b101)
    |=> pc_o == PC_W'($past(pc_o) + 1'b1)); // R8

  AST_EXT_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    (exec_i && src_ext_i) |=> $stable(pc_o)); // R9
endmodule

bind sc8_core sc8_core_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .exec_i(exec_i), .src_ext_i(src_ext_i),
  .cur_instr(cur_instr), .pc_o(pc_o), .dbg_addr_i(dbg_addr_i),
  .dbg_data_o(dbg_data_o)
);

// File: tb/sc8_core_tb.sv
`timescale 1ns/1ps
module sc8_core_tb;
  localparam logic [255:0] BENCH_ROM = {
    16'hA56E, 16'hE000, 16'hA001, 16'h4433,   // 15..12
    16'hC000, 16'h8000, 16'h0203, 16'hA121,   // 11..8
    16'hFFFF, 16'h6000, 16'hA112, 16'h4312,   // 7..4
    16'h2021, 16'h2010, 16'h1103, 16'h1005};  // 3..0

  logic clk = 1'b0;
  logic rst_n, exec_i, src_ext_i;
  logic [15:0] ext_instr_i, next_instr_o;
  logic [3:0]  dbg_addr_i, pc_o;
  logic [7:0]  dbg_data_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] rf_m [16];
  logic [7:0] dm_m [16];
  logic [3:0] pc_m;

  always #2.5 clk = ~clk;

  sc8_core #(.IMEM_DEPTH(16), .ROM_IMAGE(BENCH_ROM)) u_dut (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .src_ext_i(src_ext_i),
    .ext_instr_i(ext_instr_i), .dbg_addr_i(dbg_addr_i), .dbg_data_o(dbg_data_o),
    .next_instr_o(next_instr_o), .pc_o(pc_o)
  );

  function automatic logic [15:0] rom_at(input logic [3:0] a);
    return BENCH_ROM[a*16 +: 16];
  endfunction

  function automatic logic [3:0] next_pc(input logic [3:0] pc, input logic tk,
                                         input logic [3:0] off);
    return pc + 4'd1 + (tk ? off : 4'd0);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_dm(input logic [3:0] a, input logic [7:0] exp, input string tag);
    dbg_addr_i = a;
    #0.1;
    check(tag, {8'h00, dbg_data_o}, {8'h00, exp});
  endtask

  task automatic sweep(input string tag);
    check({tag, " pc"}, {12'h0, pc_o}, {12'h0, pc_m});
    check("R11 next_instr", next_instr_o, rom_at(pc_m));
    for (int a = 0; a < 16; a++) check_dm(4'(a), dm_m[a], {tag, " R12 dmem"});
  endtask

  task automatic model(input logic [15:0] w, input logic ext);
    logic tk = 1'b0;
    case (w[15:13])
      3'b000: dm_m[w[11:8]] = w[12] ? w[7:0] : rf_m[w[3:0]];
      3'b001: rf_m[w[7:4]] = dm_m[w[3:0]];
      3'b010: rf_m[w[11:8]] = rf_m[w[7:4]] + rf_m[w[3:0]];
      3'b101: tk = (rf_m[w[11:8]] == rf_m[w[7:4]]);
      default: ;
    endcase
    if (!ext) pc_m = next_pc(pc_m, tk, w[3:0]);
  endtask

  task automatic run(input logic en, input logic ext, input logic [15:0] w, input string tag);
    logic [15:0] cur;
    @(negedge clk);
    exec_i = en; src_ext_i = ext; ext_instr_i = w;
    cur = ext ? w : rom_at(pc_m);
    @(posedge clk);
    if (en) model(cur, ext);
    @(negedge clk);
    exec_i = 1'b0;
    sweep(tag);
  endtask

  task automatic dump_rf(input string tag);
    for (int r = 0; r < 16; r++) begin
      run(1'b1, 1'b1, {4'b0000, 4'hF, 4'h0, 4'(r)}, tag);
      check_dm(4'hF, rf_m[r], {tag, " R4 reg"});
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; exec_i = 1'b0; src_ext_i = 1'b0; ext_instr_i = '0; dbg_addr_i = '0;
    for (int i = 0; i < 16; i++) begin rf_m[i] = '0; dm_m[i] = '0; end
    pc_m = '0;
    repeat (3) @(negedge clk);
    sweep("R1 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    dump_rf("R1 reset rf");

    // R2: strobe low with a store present
    run(1'b0, 1'b1, 16'h1577, "R2 idle");
    check_dm(4'h5, 8'h00, "R2 idle store blocked");
    // R3: immediate store
    run(1'b1, 1'b1, 16'h1503, "R3");
    check_dm(4'h5, 8'h03, "R3 imm store");
    // R5/R6: load then wrapping add, R4: register store
    run(1'b1, 1'b1, 16'h10C8, "R3");
    run(1'b1, 1'b1, 16'h1164, "R3");
    run(1'b1, 1'b1, 16'h2F10, "R5");   // [11:8] don't-care
    run(1'b1, 1'b1, 16'h2021, "R5");
    run(1'b1, 1'b1, 16'h5312, "R6");   // bit 12 set, ignored
    run(1'b1, 1'b1, 16'h0203, "R4");
    check_dm(4'h2, 8'h2C, "R6 wrap 200+100");
    // R10: reserved opcodes
    run(1'b1, 1'b1, 16'h7FFF, "R10");
    run(1'b1, 1'b1, 16'h9234, "R10");
    run(1'b1, 1'b1, 16'hD567, "R10");
    run(1'b1, 1'b1, 16'hF89A, "R10");
    dump_rf("R10 regs");
    // R9: external branch, equal registers
    run(1'b1, 1'b1, 16'hA113, "R9");
    // R7/R8: program from the store
    for (int s = 0; s < 30; s++) run(1'b1, 1'b0, 16'h0000, "R7 R8 rom");
    // mixed random
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] w = 16'($urandom);
      logic en  = ($urandom % 4) != 0;
      logic ext = ($urandom % 2) != 0;
      if (($urandom % 4) == 0) w[11:4] = {w[7:4], w[7:4]};
      run(en, ext, w, ext ? "R9 rand" : "R7 R8 rand");
    end
    dump_rf("R6 final regs");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule